// File: doc/BRIEF.md
# TDM Input Stream Bit Aligner

This block recovers the serial data of one TDM input stream. The stream runs at one of four rates: 2.048, 4.096, 8.192 or 16.384 Mbps. A one-cycle phase tick, `qtick`, comes in at four times the fastest bit rate. One bit cell at rate code r therefore spans `32 >> r` ticks. A frame pulse, `frm_sync`, counts only when it is high in a tick cycle. That tick is tick 0 of cell 0 of the frame.

Within each cell the block samples the data line at one programmable quarter point. It lets the stream lag the frame pulse by 0 to 7 whole bit cells. Each recovered bit leaves with its index within the frame and a mark on the first bit of every 8-bit channel.

A 16-bit control word holds three fields, and the field positions are part of the behaviour:
- bits 8:6 hold the bit delay;
- bits 5:4 hold the sampling code;
- bits 3:0 hold the rate code.

A write goes into a pending copy, which is what readback shows. The pending copy becomes active only at a frame pulse.

The recovered-bit output is a one-way stream with valid only and no back-pressure. TDM data cannot stall, so the consumer must accept every beat in the cycle it appears.

Top module: `tdm_bit_aligner`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and `rx_valid` is low. The active configuration is rate code 0, sampling code 00 and delay 0.
- R2: `cfg_rdata` returns the last written word with bits 15:9 forced to 0 and bits 8:0 as written.
- R3: A write changes the active configuration only at the next frame tick, never within a frame. A write in the frame tick's own cycle takes effect for the frame that starts there.
- R4: At rate codes 0 to 2, let Q = `8 >> rate` ticks and let p be the tick index within the cell. Sampling code 00 samples at p = 3Q-1, code 01 at p = Q-1, code 10 at p = 2Q-1 and code 11 at p = 4Q-1.
- R5: At rate code 3 (cell of 4 ticks), codes 00 and 01 sample at p = 1, and codes 10 and 11 sample at p = 3.
- R6: With delay d, stream bit n is the bit sampled in cell n+d after the frame tick. The cells before that produce no output. Bit indices restart at 0 at each frame tick.
- R7: Each sample raises `rx_valid` for exactly one cycle, the cycle after the sampling tick, carrying `rx_bit` and `rx_idx`. `rx_chan_start` is high exactly when `rx_valid` is high and `rx_idx[2:0]` is 0.
- R8: Rate codes 4 to 15 disable the stream, and `rx_valid` stays low for the whole frame.
- R9: No bit is produced after reset until the first frame tick.
- R10: Only tick cycles advance the phase. Idle cycles between ticks change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qtick | input | 1 | Quarter-phase tick of the fastest rate |
| frm_sync | input | 1 | Frame pulse, honoured only with `qtick` |
| sdin | input | 1 | Serial input data |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Pending control word readback |
| rx_bit | output | 1 | Recovered bit |
| rx_valid | output | 1 | Recovered-bit strobe |
| rx_idx | output | 12 | Bit index within the frame |
| rx_chan_start | output | 1 | First bit of a channel |

## Verification
A control write can land in the same cycle as the frame tick that loads the active configuration. The block must then use the new word, including its delay, for the frame starting there. The bench provokes this by pulsing the write strobe in the frame-tick cycle, and provokes the opposite case with a write in mid-frame. In both frames the data line carries the correct bit only at the tick that the expected configuration samples. Each frame is judged by its count of recovered bits and by a bit-by-bit comparison with the bench's own serializer.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  localparam int NRATES = 4;
  localparam int RS_W   = $clog2(NRATES);
  localparam int PH_W   = $clog2(4 << (NRATES - 1));
  localparam int DLY_W  = 3;
  localparam int SMP_W  = 2;
  localparam int RATE_W = 4;
  localparam int CFG_W  = DLY_W + SMP_W + RATE_W;
  localparam int REG_W  = 16;
  localparam int IDX_W  = 12;
  localparam int CNT_W  = IDX_W + 1;

  typedef struct packed {
    logic [DLY_W-1:0]  dly;
    logic [SMP_W-1:0]  smp;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  // quarter number (1..4) that a sampling code selects
  function automatic logic [2:0] quarter_of(input logic fast, input logic [SMP_W-1:0] code);
    logic [2:0] q;
    if (fast) begin
      q = code[1] ? 3'd4 : 3'd2;
    end else begin
      case (code)
        2'b00:   q = 3'd3;
        2'b01:   q = 3'd1;
        2'b10:   q = 3'd2;
        default: q = 3'd4;
      endcase
    end
    return q;
  endfunction
endpackage

// File: rtl/aligner_cfg.sv
module aligner_cfg
  import aligner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             frame_tick,
  output logic [REG_W-1:0] rdata,
  output cfg_t             act,
  output cfg_t             load
);
  cfg_t pend;

  // a write in the frame-tick cycle is forwarded into the load
  assign load  = we ? cfg_t'(wdata[CFG_W-1:0]) : pend;
  assign rdata = {{(REG_W-CFG_W){1'b0}}, pend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      if (we)         pend <= cfg_t'(wdata[CFG_W-1:0]);
      if (frame_tick) act  <= load;
    end
  end
endmodule

// File: rtl/aligner_phase.sv
module aligner_phase
  import aligner_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic qtick,
  input  logic frame_tick,
  input  cfg_t act,
  output logic hit,
  output logic rate_ok
);
  logic [PH_W-1:0] ph, cur, tgt, last;
  logic [RS_W-1:0] sh;
  logic [2:0]      qsel;
  logic            synced;

  assign rate_ok = act.rate < RATE_W'(NRATES);
  assign sh      = RS_W'(NRATES - 1) - act.rate[RS_W-1:0];
  assign qsel    = quarter_of(act.rate[RS_W-1:0] == RS_W'(NRATES - 1), act.smp);
  assign tgt     = (PH_W'(qsel) << sh) - PH_W'(1);
  assign last    = (PH_W'(4) << sh) - PH_W'(1);

  always_comb begin
    if (frame_tick)     cur = '0;
    else if (ph == last) cur = '0;
    else                cur = ph + PH_W'(1);
  end

  assign hit = qtick && !frame_tick && synced && rate_ok && (cur == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      synced <= 1'b0;
    end else if (qtick) begin
      ph <= cur;
      if (frame_tick) synced <= 1'b1;
    end
  end
endmodule

// File: rtl/aligner_count.sv
module aligner_count
  import aligner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [DLY_W-1:0] load_dly,
  input  logic             hit,
  input  logic             sdin,
  output logic             rx_bit,
  output logic             rx_valid,
  output logic [IDX_W-1:0] rx_idx,
  output logic             rx_chan_start
);
  logic [CNT_W-1:0] cnt;
  logic             live;

  // negative count marks cells still inside the delay
  assign live = hit && !cnt[CNT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      rx_bit        <= 1'b0;
      rx_valid      <= 1'b0;
      rx_idx        <= '0;
      rx_chan_start <= 1'b0;
    end else begin
      if (frame_tick) cnt <= CNT_W'(0) - CNT_W'(load_dly);
      else if (hit)   cnt <= cnt + CNT_W'(1);
      rx_valid      <= live;
      rx_chan_start <= live && (cnt[2:0] == 3'd0);
      if (live) begin
        rx_bit <= sdin;
        rx_idx <= cnt[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tdm_bit_aligner.sv
module tdm_bit_aligner
  import aligner_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qtick,
  input  logic             frm_sync,
  input  logic             sdin,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             rx_bit,
  output logic             rx_valid,
  output logic [IDX_W-1:0] rx_idx,
  output logic             rx_chan_start
);
  logic frame_tick, hit, rate_ok;
  cfg_t act, load;

  assign frame_tick = qtick && frm_sync;

  aligner_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .frame_tick(frame_tick), .rdata(cfg_rdata), .act(act), .load(load)
  );

  aligner_phase u_phase (
    .clk(clk), .rst_n(rst_n), .qtick(qtick), .frame_tick(frame_tick),
    .act(act), .hit(hit), .rate_ok(rate_ok)
  );

  aligner_count u_count (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .load_dly(load.dly),
    .hit(hit), .sdin(sdin), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .rx_idx(rx_idx), .rx_chan_start(rx_chan_start)
  );
endmodule

// File: rtl/aligner_chk.sv
module aligner_chk
  import aligner_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             qtick,
  input logic             frm_sync,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             rx_valid,
  input logic [IDX_W-1:0] rx_idx,
  input logic             rx_chan_start,
  input cfg_t             act_word
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:CFG_W] == '0);

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(qtick && frm_sync) |=> $stable(act_word));

  assert_quiet_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qtick && frm_sync) |=> !rx_valid);

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_chan_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_chan_start |-> (rx_valid && rx_idx[2:0] == 3'd0));

  assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_word.rate >= RATE_W'(NRATES)) |=> !rx_valid);
endmodule

bind tdm_bit_aligner aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .qtick(qtick), .frm_sync(frm_sync),
  .cfg_rdata(cfg_rdata), .rx_valid(rx_valid), .rx_idx(rx_idx),
  .rx_chan_start(rx_chan_start), .act_word(act)
);

// File: tb/tdm_bit_aligner_bench.sv
module tdm_bit_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qtick = 1'b0;
  logic        frm_sync = 1'b0;
  logic        sdin = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        rx_bit, rx_valid, rx_chan_start;
  logic [11:0] rx_idx;

  int checks = 0;
  int errors = 0;
  int mon_cnt = 0, mon_bad = 0, mon_exp = 0, mon_seed = 0, mon_cs = 0;
  logic prev_v = 1'b0;
  logic [8:0] pend = '0;

  always #5 clk = ~clk;

  tdm_bit_aligner u_tdm_bit_aligner (
    .clk(clk), .rst_n(rst_n), .qtick(qtick), .frm_sync(frm_sync), .sdin(sdin),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .rx_idx(rx_idx),
    .rx_chan_start(rx_chan_start)
  );

  function automatic logic refbit(input int n, input int seed);
    logic [15:0] v;
    v = 16'(n * 29 + seed * 7 + (n >> 3));
    return ^v;
  endfunction

  // sample tick within a cell, from R4 and R5
  function automatic int tgt_tick(input int rate, input int code);
    int q;
    if (rate == 3) q = (code >= 2) ? 4 : 2;
    else case (code)
      0: q = 3;
      1: q = 1;
      2: q = 2;
      default: q = 4;
    endcase
    return q * (8 >> rate) - 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output monitor, sampled 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rx_valid) begin
      mon_cnt++;
      if (rx_bit != refbit(int'(rx_idx), mon_seed)) mon_bad++;
      if (int'(rx_idx) != mon_exp) mon_bad++;
      if (rx_chan_start != (rx_idx[2:0] == 3'd0)) mon_bad++;
      if (prev_v) mon_bad++;
      if (rx_chan_start) mon_cs++;
      mon_exp++;
    end else if (rx_chan_start) mon_bad++;
    prev_v = rx_valid;
  end

  task automatic cfg_write(input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    pend = w[8:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      qtick = 1'b0; frm_sync = 1'b0; cfg_we = 1'b0;
    end
  endtask

  // one frame: wr_cell -1 none, 0 with the frame tick, >0 mid-frame
  task automatic run_frame(input int nbits, input int gap, input int wr_cell,
                           input logic [15:0] wr_word, input int seed, input string tag);
    logic [8:0] a;
    int rate, d, code, cticks, tgt, n, expn;
    @(negedge clk);
    mon_cnt = 0; mon_bad = 0; mon_exp = 0; mon_cs = 0; mon_seed = seed;
    a = (wr_cell == 0) ? wr_word[8:0] : pend;
    rate = int'(a[3:0]); code = int'(a[5:4]); d = int'(a[8:6]);
    cticks = (rate < 4) ? (32 >> rate) : 8;
    tgt = (rate < 4) ? tgt_tick(rate, code) : 0;
    for (int c = 0; c < nbits; c++) begin
      for (int p = 0; p < cticks; p++) begin
        if (!(c == 0 && p == 0)) @(negedge clk);
        qtick = 1'b1;
        frm_sync = (c == 0 && p == 0);
        cfg_we = 1'b0;
        if (p == 0 && c == wr_cell) begin
          cfg_we = 1'b1; cfg_wdata = wr_word; pend = wr_word[8:0];
        end
        n = c - d;
        if (n < 0) sdin = p[0];
        else sdin = (p == tgt) ? refbit(n, seed) : ~refbit(n, seed);
        if (gap > 0) begin
          for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            qtick = 1'b0; frm_sync = 1'b0; cfg_we = 1'b0; sdin = ~sdin;
          end
        end
      end
    end
    idle(3);
    expn = (rate < 4) ? ((nbits > d) ? nbits - d : 0) : 0;
    check(mon_cnt == expn, tag, "bit count", mon_cnt, expn);
    check(mon_bad == 0, tag, "mismatches", mon_bad, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(rx_valid == 1'b0, "R1", "valid after reset", int'(rx_valid), 0);
    check(cfg_rdata == 16'h0, "R1", "readback after reset", int'(cfg_rdata), 0);
    // R9: ticks without any frame pulse
    mon_cnt = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      qtick = 1'b1; frm_sync = 1'b0; sdin = i[1];
    end
    idle(3);
    check(mon_cnt == 0, "R9", "bits before first frame", mon_cnt, 0);
    // R1: default configuration used by the first frame
    run_frame(20, 0, -1, 16'h0, 3, "R1 default");
  endtask

  task automatic t_readback;
    cfg_write(16'hFFFF);
    check(cfg_rdata == 16'h01FF, "R2", "readback all ones", int'(cfg_rdata), 16'h01FF);
    cfg_write(16'hA5C3);
    check(cfg_rdata == 16'h01C3, "R2", "readback pattern", int'(cfg_rdata), 16'h01C3);
  endtask

  task automatic t_sweep;
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 8; d++)
        for (int c = 0; c < 4; c++) begin
          cfg_write(16'((d << 6) | (c << 4) | r));
          run_frame(20, 0, -1, 16'h0, r * 32 + d * 4 + c,
                    (r == 3) ? "R5 R6 R7" : "R4 R6 R7");
        end
  endtask

  task automatic t_chan_marks;
    cfg_write(16'h0002);
    run_frame(20, 0, -1, 16'h0, 11, "R7 marks");
    check(mon_cs == 3, "R7", "channel starts", mon_cs, 3);
  endtask

  task automatic t_write_timing;
    // R3: mid-frame write waits for the next frame
    cfg_write(16'((2 << 6) | (1 << 4) | 1));
    run_frame(16, 0, 5, 16'((5 << 6) | (3 << 4) | 2), 21, "R3 mid-frame old");
    run_frame(16, 0, -1, 16'h0, 22, "R3 mid-frame new");
    // R3: write on the frame tick applies at once
    run_frame(16, 0, 0, 16'((4 << 6) | (0 << 4) | 3), 23, "R3 on frame tick");
    run_frame(16, 0, 0, 16'((7 << 6) | (2 << 4) | 0), 24, "R3 on frame tick slow");
  endtask

  task automatic t_disable;
    cfg_write(16'h0009);
    run_frame(12, 0, -1, 16'h0, 31, "R8 rate 9");
    cfg_write(16'h01BF);
    run_frame(12, 0, -1, 16'h0, 32, "R8 rate 15");
    cfg_write(16'h0004);
    run_frame(12, 0, -1, 16'h0, 33, "R8 rate 4");
  endtask

  task automatic t_gaps;
    cfg_write(16'((3 << 6) | (2 << 4) | 3));
    run_frame(16, 2, -1, 16'h0, 41, "R10 gap 2");
    cfg_write(16'((1 << 6) | (1 << 4) | 1));
    run_frame(12, 1, -1, 16'h0, 42, "R10 gap 1");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_readback;
        t_sweep;
        t_chan_marks;
        t_write_timing;
        t_disable;
        t_gaps;
      end
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule